// File: doc/BRIEF.md
# Locked Expiry-Counting Watchdog

This block is a watchdog that does not keep its own time base. It watches a bank of single-cycle expiry pulses that come from general-purpose timers elsewhere on the chip. It picks one of them through a configuration field and counts its pulses. When the count reaches a programmed period, the watchdog fires. Firing raises any enabled mix of four actions: a normal interrupt, a fast interrupt, a system reset request and a power-controller reset request.

Software controls the block through three write-only registers on a simple write port: configuration, command and unlock. A command is accepted only when the previous write to the unlock register carried the magic key. One key admits exactly one command, so a runaway program cannot stop the watchdog by accident. A second start command re-arms the count and clears the interrupt levels. A disable command stops the block and clears every output.

Top module: `locked_wdog`

## Requirements
- R1: The configuration register sits at offset 0x180. Its bits 3:0 select the source pulse and bits 11:4 hold the period. Bit 12 enables the interrupt, bit 13 the fast interrupt, bit 14 the system reset and bit 15 the power-controller reset. A configuration write needs no unlock.
- R2: A write of exactly 0x0000C45A to offset 0x18C unlocks the next command. A write of any other value to 0x18C leaves the block locked.
- R3: A command write to offset 0x188 while locked has no effect. Every command write, accepted or not, locks the block again.
- R4: An accepted command with bit 0 set and bit 1 clear starts counting. It zeroes the count and drops both interrupt levels on the following cycle.
- R5: An accepted command with bit 1 set stops counting and zeroes the count. It drops all four outputs on the following cycle, including reset pulses under way, and takes priority over bit 0.
- R6: While counting, only pulses on the selected source advance the count. Pulses on other sources, and any pulse while stopped, are ignored.
- R7: The watchdog fires on the Nth selected pulse, where N is the period field and a period of 0 acts as 1. The outputs change on the cycle after that pulse.
- R8: After firing, an enabled interrupt or fast interrupt stays high until an accepted start or disable.
- R9: After firing, an enabled system or power-controller reset output is high for exactly RST_CYCLES cycles (4 by default). A disabled action stays low.
- R10: After firing, the count restarts from zero and counting goes on, so the watchdog fires again after another N selected pulses.
- R11: After reset all outputs are low, the block is stopped and locked, and the configuration is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (12) | Register byte offset |
| wr_data | input | 32 | Register write data |
| src_pulse | input | NUM_SRC (16) | Expiry pulses from the source timers, one per source |
| irq_o | output | 1 | Interrupt level |
| fiq_o | output | 1 | Fast interrupt level |
| sys_rst_o | output | 1 | System reset request pulse |
| pmc_rst_o | output | 1 | Power-controller reset request pulse |

## Verification
The assertions assume that a source pulse is a one-cycle event. They also assume that the write port carries at most one register write per cycle, and that the reset pulse length is at least two cycles. The stimulus respects this: each write and each pulse lasts exactly one cycle. The sequence drives sources that are not selected, wrong unlock keys, commands without a key, a zero period, and a disable while a reset pulse is under way. A behavioural model computes the expected outputs and is compared with the design on every cycle.

// File: rtl/locked_wdog_pkg.sv
package locked_wdog_pkg;

    localparam int SEL_W = 4;
    localparam int PER_W = 8;

    localparam int unsigned OFS_CFG    = 32'h180;
    localparam int unsigned OFS_CMD    = 32'h188;
    localparam int unsigned OFS_UNLOCK = 32'h18C;
    localparam logic [31:0] UNLOCK_KEY = 32'h0000_C45A;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_STOP_BIT  = 1;

    typedef struct packed {
        logic             pmc_en;
        logic             sys_en;
        logic             fiq_en;
        logic             irq_en;
        logic [PER_W-1:0] period;
        logic [SEL_W-1:0] sel;
    } wd_cfg_t;

    localparam int CFG_W = $bits(wd_cfg_t);

endpackage

// File: rtl/locked_wdog_regs.sv
module locked_wdog_regs
    import locked_wdog_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output wd_cfg_t           cfg_o,
    output logic              cmd_start_o,
    output logic              cmd_stop_o,
    output logic              unlocked_o
);

    typedef struct packed {
        wd_cfg_t cfg;
        logic    unl;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic        hit_cfg, hit_cmd, hit_unl;
    logic        start_d, stop_d;

    always_comb begin
        hit_cfg = wr_en && (wr_addr == ADDR_W'(OFS_CFG));
        hit_cmd = wr_en && (wr_addr == ADDR_W'(OFS_CMD));
        hit_unl = wr_en && (wr_addr == ADDR_W'(OFS_UNLOCK));

        st_d    = st_q;
        start_d = 1'b0;
        stop_d  = 1'b0;

        if (hit_cfg) begin
            st_d.cfg = wd_cfg_t'(wr_data[CFG_W-1:0]);
        end
        if (hit_unl) begin
            st_d.unl = (wr_data == UNLOCK_KEY);
        end
        if (hit_cmd) begin
            st_d.unl = 1'b0;
            if (st_q.unl) begin
                stop_d  = wr_data[CMD_STOP_BIT];
                start_d = wr_data[CMD_START_BIT] && !wr_data[CMD_STOP_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o       = st_q.cfg;
    assign cmd_start_o = start_d;
    assign cmd_stop_o  = stop_d;
    assign unlocked_o  = st_q.unl;

    // R3: any command write leaves the block locked afterwards
    p_cmd_relocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFS_CMD)) |=> !unlocked_o);

endmodule

// File: rtl/locked_wdog_srcmux.sv
module locked_wdog_srcmux
    import locked_wdog_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick_o
);

    logic [NUM_SRC-1:0] match;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        assign match[gi] = src_pulse[gi] && (sel == SEL_W'(gi));
    end

    assign tick_o = |match;

endmodule

// File: rtl/locked_wdog_core.sv
module locked_wdog_core
    import locked_wdog_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  wd_cfg_t cfg,
    input  logic    cmd_start,
    input  logic    cmd_stop,
    input  logic    tick,
    output logic    irq_o,
    output logic    fiq_o,
    output logic    sys_rst_o,
    output logic    pmc_rst_o,
    output logic    running_o
);

    localparam int RCW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic             run;
        logic [PER_W-1:0] cnt;
        logic             irq;
        logic             fiq;
        logic [RCW-1:0]   sys_cnt;
        logic [RCW-1:0]   pmc_cnt;
    } core_state_t;

    core_state_t      c_d, c_q;
    logic [PER_W-1:0] per_eff;
    logic [PER_W:0]   cnt_inc;
    logic             fire;

    always_comb begin
        c_d     = c_q;
        fire    = 1'b0;
        per_eff = (cfg.period == '0) ? PER_W'(1) : cfg.period;
        cnt_inc = {1'b0, c_q.cnt} + (PER_W+1)'(1);

        if (c_q.sys_cnt != '0) c_d.sys_cnt = c_q.sys_cnt - RCW'(1);
        if (c_q.pmc_cnt != '0) c_d.pmc_cnt = c_q.pmc_cnt - RCW'(1);

        if (cmd_stop) begin
            c_d = '0;
        end else if (cmd_start) begin
            c_d.run = 1'b1;
            c_d.cnt = '0;
            c_d.irq = 1'b0;
            c_d.fiq = 1'b0;
        end else if (c_q.run && tick) begin
            if (cnt_inc >= {1'b0, per_eff}) begin
                fire    = 1'b1;
                c_d.cnt = '0;
            end else begin
                c_d.cnt = cnt_inc[PER_W-1:0];
            end
        end

        if (fire) begin
            if (cfg.irq_en) c_d.irq = 1'b1;
            if (cfg.fiq_en) c_d.fiq = 1'b1;
            if (cfg.sys_en) c_d.sys_cnt = RCW'(RST_CYCLES);
            if (cfg.pmc_en) c_d.pmc_cnt = RCW'(RST_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign irq_o     = c_q.irq;
    assign fiq_o     = c_q.fiq;
    assign sys_rst_o = (c_q.sys_cnt != '0);
    assign pmc_rst_o = (c_q.pmc_cnt != '0);
    assign running_o = c_q.run;

    // R4: an accepted start drops both interrupt levels and the count
    p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cmd_stop) |=> (!irq_o && !fiq_o && c_q.cnt == '0));

    // R5: disable drops every output
    p_stop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (!irq_o && !fiq_o && !sys_rst_o && !pmc_rst_o && !running_o));

    // R6: a stopped watchdog holds no partial count
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> (c_q.cnt == '0));

    // R8: interrupt level held while no start or disable arrives
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !cmd_start && !cmd_stop) |=> irq_o);

    // R9: a system reset pulse begins only when enabled at the firing edge
    p_sys_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(cfg.sys_en));

    // R9: a fresh reset pulse lasts at least two cycles
    p_pmc_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pmc_rst_o) && !cmd_stop) |=> pmc_rst_o);

endmodule

// File: rtl/locked_wdog.sv
module locked_wdog
    import locked_wdog_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_SRC    = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [NUM_SRC-1:0] src_pulse,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               sys_rst_o,
    output logic               pmc_rst_o
);

    wd_cfg_t cfg;
    logic    cmd_start, cmd_stop, unlocked, tick, running;

    locked_wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cfg_o       (cfg),
        .cmd_start_o (cmd_start),
        .cmd_stop_o  (cmd_stop),
        .unlocked_o  (unlocked)
    );

    locked_wdog_srcmux #(.NUM_SRC(NUM_SRC)) u_mux (
        .src_pulse (src_pulse),
        .sel       (cfg.sel),
        .tick_o    (tick)
    );

    locked_wdog_core #(.RST_CYCLES(RST_CYCLES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .tick      (tick),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o),
        .sys_rst_o (sys_rst_o),
        .pmc_rst_o (pmc_rst_o),
        .running_o (running)
    );

    // R3: counting can only begin out of an unlocked state
    p_start_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(unlocked));

endmodule

// File: tb/locked_wdog_tb.sv
module locked_wdog_tb;

    localparam int RSTC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] src_pulse = '0;
    logic        irq_o, fiq_o, sys_rst_o, pmc_rst_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string tag = "R11";

    always #2.5 clk = ~clk;

    locked_wdog u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .src_pulse (src_pulse),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o),
        .sys_rst_o (sys_rst_o),
        .pmc_rst_o (pmc_rst_o)
    );

    // behavioural reference
    logic [15:0] m_cfg;
    bit          m_unl, m_run, m_irq, m_fiq;
    int          m_cnt, m_sys, m_pmc;

    always @(posedge clk or negedge rst_n) begin : model
        int  per, ns, np;
        bit  dis, go, fire;
        if (!rst_n) begin
            m_cfg <= '0; m_unl <= 0; m_run <= 0; m_irq <= 0; m_fiq <= 0;
            m_cnt <= 0; m_sys <= 0; m_pmc <= 0;
        end else begin
            dis = 0; go = 0; fire = 0;
            if (wr_en) begin
                if (wr_addr == 12'h180) m_cfg <= wr_data[15:0];
                else if (wr_addr == 12'h18C) m_unl <= (wr_data == 32'h0000C45A);
                else if (wr_addr == 12'h188) begin
                    m_unl <= 0;
                    if (m_unl) begin
                        dis = wr_data[1];
                        go  = wr_data[0] && !wr_data[1];
                    end
                end
            end
            ns = (m_sys > 0) ? m_sys - 1 : 0;
            np = (m_pmc > 0) ? m_pmc - 1 : 0;
            if (dis) begin
                m_run <= 0; m_cnt <= 0; m_irq <= 0; m_fiq <= 0; ns = 0; np = 0;
            end else if (go) begin
                m_run <= 1; m_cnt <= 0; m_irq <= 0; m_fiq <= 0;
            end else if (m_run && src_pulse[m_cfg[3:0]]) begin
                per = int'(m_cfg[11:4]);
                if (per == 0) per = 1;
                if (m_cnt + 1 >= per) begin
                    fire = 1;
                    m_cnt <= 0;
                end else begin
                    m_cnt <= m_cnt + 1;
                end
            end
            if (fire) begin
                if (m_cfg[12]) m_irq <= 1;
                if (m_cfg[13]) m_fiq <= 1;
                if (m_cfg[14]) ns = RSTC;
                if (m_cfg[15]) np = RSTC;
            end
            m_sys <= ns;
            m_pmc <= np;
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // compare with the model every cycle
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(tag, irq_o,     m_irq,     "irq_o");
            check(tag, fiq_o,     m_fiq,     "fiq_o");
            check(tag, sys_rst_o, m_sys > 0, "sys_rst_o");
            check(tag, pmc_rst_o, m_pmc > 0, "pmc_rst_o");
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        src_pulse = 16'(1) << idx;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // cfg word: sel 3:0, period 11:4, enables 12..15
    function automatic logic [31:0] cfgw(input int sel, input int per, input logic [3:0] en);
        return {16'h0, en, 8'(per), 4'(sel)};
    endfunction

    initial begin
        int hi;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        tag = "R11";
        check("R11", irq_o | fiq_o | sys_rst_o | pmc_rst_o, 1'b0, "outputs after reset");

        // R3: command without unlock ignored
        tag = "R3";
        wr(12'h180, cfgw(2, 3, 4'b0001));
        wr(12'h188, 32'h1);
        for (int i = 0; i < 3; i++) pulse(2);
        check("R3", irq_o, 1'b0, "irq after locked start");

        // R2: wrong key keeps it locked
        tag = "R2";
        wr(12'h18C, 32'h0000_1234);
        wr(12'h188, 32'h1);
        for (int i = 0; i < 3; i++) pulse(2);
        check("R2", irq_o, 1'b0, "irq after wrong key");

        // R6/R7: proper start, foreign source ignored, fires on 3rd pulse
        tag = "R6";
        wr(12'h18C, 32'h0000_C45A);
        wr(12'h188, 32'h1);
        for (int i = 0; i < 4; i++) pulse(5);
        check("R6", irq_o, 1'b0, "irq after unselected pulses");
        tag = "R7";
        pulse(2); pulse(2);
        check("R7", irq_o, 1'b0, "irq after 2 of 3");
        pulse(2);
        check("R7", irq_o, 1'b1, "irq on 3rd pulse");
        check("R1", fiq_o, 1'b0, "fiq not enabled");

        // R8 and R3 single-use key
        tag = "R8";
        idle(5);
        check("R8", irq_o, 1'b1, "irq held");
        wr(12'h188, 32'h2);
        check("R3", irq_o, 1'b1, "key already consumed");

        // R4: restart clears interrupt
        tag = "R4";
        wr(12'h18C, 32'h0000_C45A);
        wr(12'h188, 32'h1);
        check("R4", irq_o, 1'b0, "irq after restart");

        // R7 zero period, R9 pulse length and enables
        tag = "R9";
        wr(12'h180, cfgw(7, 0, 4'b0110));
        pulse(7);
        check("R7", fiq_o, 1'b1, "period 0 fires on 1st pulse");
        check("R9", sys_rst_o, 1'b1, "sys reset started");
        hi = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (sys_rst_o) hi++;
        end
        checks++;
        if (hi != RSTC) begin
            fails++;
            $display("FAIL R9 sys pulse length actual=%0d expected=%0d", hi, RSTC);
        end
        check("R9", pmc_rst_o, 1'b0, "pmc reset not enabled");
        check("R1", irq_o, 1'b0, "irq not enabled");

        // R10: refire after another period
        tag = "R10";
        wr(12'h180, cfgw(9, 2, 4'b1000));
        wr(12'h18C, 32'h0000_C45A);
        wr(12'h188, 32'h1);
        pulse(9);
        check("R10", pmc_rst_o, 1'b0, "no fire after 1 of 2");
        pulse(9);
        check("R10", pmc_rst_o, 1'b1, "first fire");
        idle(6);
        check("R10", pmc_rst_o, 1'b0, "pulse finished");
        pulse(9);
        pulse(9);
        check("R10", pmc_rst_o, 1'b1, "second fire");

        // R5: disable (both bits) clears a pulse under way, stops counting
        tag = "R5";
        wr(12'h18C, 32'h0000_C45A);
        wr(12'h188, 32'h3);
        check("R5", pmc_rst_o, 1'b0, "pmc cleared by disable");
        pulse(9); pulse(9); pulse(9);
        check("R5", pmc_rst_o, 1'b0, "no count while stopped");
        check("R6", sys_rst_o | irq_o | fiq_o, 1'b0, "outputs idle while stopped");

        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule